// File: doc/BRIEF.md
# Float to Fixed-Point Coefficient Converter

This block turns one IEEE 754 single-precision word into a signed two's-complement coefficient for a color-matrix register. It reads the sign from bit 31, the biased exponent from bits 30:23 and the fraction from bits 22:0. It restores the hidden leading one above the fraction and scales the 24-bit significand by a power of two. It then applies the sign and keeps only the low INT_W+FRAC_W+1 bits of the result. The magnitude is always truncated toward zero. With the default parameters the field is 11 bits: one sign bit, two integer bits and eight fraction bits.

A caller presents the word with `in_valid` high for one cycle. The converted coefficient appears one clock later with `out_valid`. Between results the outputs hold their last value. If the value needs more left shift than the datapath allows, `out_ovf` rises and the coefficient saturates.

Top module: `flt2fix_coef`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_ovf` and `out_coef` are all zero.
- R2: `out_valid` is high in exactly those cycles that follow a cycle where `in_valid` was high. A stream of back-to-back inputs therefore gives one result per cycle.
- R3: Let the effective shift be s = E − 127 + FRAC_W, where E is bits 30:23. The significand is bits 22:0 with a one added at bit 23. For a positive input with s in 0..23, `out_coef` is the significand shifted right by 23 − s, with the dropped bits discarded, and `out_ovf` is 0. For example, 1.0 (0x3F800000) gives 0x100, and 0x3FFFFFFF gives 0x1FF.
- R4: When s < 0, `out_coef` is 0 and `out_ovf` is 0, whatever the sign.
- R5: When 23 < s ≤ 23 + MAX_LSH (MAX_LSH defaults to 7), the significand is shifted left by s − 23. Only the low INT_W+FRAC_W+1 bits are kept, so larger magnitudes wrap, and `out_ovf` is 0.
- R6: When bit 31 is set and the case is not an overflow, `out_coef` is the two's-complement negation of the magnitude from R3 or R5, reduced to INT_W+FRAC_W+1 bits. For example, −1.0 gives 0x700 and −2^−8 gives 0x7FF.
- R7: When s > 23 + MAX_LSH, `out_ovf` is 1. `out_coef` is then 0x3FF, the largest positive code, for a positive input and 0x400, the most negative code, for a negative input.
- R8: In a cycle that follows one with `in_valid` low, `out_coef` and `out_ovf` keep their previous values, whatever `in_word` carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Single-precision input value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_coef | output | INT_W+FRAC_W+1 (11) | Signed fixed-point coefficient |
| out_ovf | output | 1 | Left shift exceeded MAX_LSH; result saturated |

## Verification
The assertions assume that `in_valid` and `in_word` are known in every cycle after reset. They also assume that the exponent field is never 0 or 255, because zero, denormal, infinity and NaN inputs fall outside this block's scope. The stimulus draws every exponent from 1..254 and weights it toward the range around the flush, right-shift, left-shift and saturation boundaries. Idle cycles carry random words, so any leak from `in_word` onto a held output would appear.

// File: rtl/flt2fix_pkg.sv
package flt2fix_pkg;

    localparam int WORD_W   = 32;
    localparam int EXP_BIAS = 127;
    localparam int MANT_W   = 24;
    localparam int FRAC_TOP = MANT_W - 1;
    localparam int SH_W     = 16;
    localparam int RSH_W    = $clog2(MANT_W);

    typedef struct packed {
        logic                   sign;
        logic signed [SH_W-1:0] shift;
        logic [MANT_W-1:0]      mant;
    } fields_t;

    typedef enum logic [1:0] {
        KIND_FLUSH = 2'd0,
        KIND_RIGHT = 2'd1,
        KIND_LEFT  = 2'd2,
        KIND_SAT   = 2'd3
    } shift_kind_e;

    function automatic shift_kind_e classify(input logic signed [SH_W-1:0] sh,
                                             input int max_lsh);
        if (sh < 0)
            return KIND_FLUSH;
        else if (sh > SH_W'(FRAC_TOP + max_lsh))
            return KIND_SAT;
        else if (sh > SH_W'(FRAC_TOP))
            return KIND_LEFT;
        else
            return KIND_RIGHT;
    endfunction

endpackage

// File: rtl/flt2fix_unpack.sv
module flt2fix_unpack
    import flt2fix_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic [WORD_W-1:0] word,
    output fields_t           fields
);

    logic [7:0] exp_field;

    assign exp_field     = word[30:23];
    assign fields.sign   = word[31];
    assign fields.mant   = {1'b1, word[22:0]};
    assign fields.shift  = SH_W'(int'(exp_field) - EXP_BIAS + FRAC_W);

endmodule

// File: rtl/flt2fix_shift.sv
module flt2fix_shift
    import flt2fix_pkg::*;
#(
    parameter int MAX_LSH = 7,
    parameter int MAG_W   = MANT_W + MAX_LSH
) (
    input  logic              clk,
    input  logic              rst,
    input  fields_t           fields,
    output shift_kind_e       kind,
    output logic [MAG_W-1:0]  mag
);

    localparam int LSH_W = (MAX_LSH < 2) ? 1 : $clog2(MAX_LSH + 1);

    logic [RSH_W-1:0] rsh_amt;
    logic [LSH_W-1:0] lsh_amt;
    logic [MAG_W-1:0] rstage [0:RSH_W];
    logic [MAG_W-1:0] lstage [0:LSH_W];

    assign kind    = classify(fields.shift, MAX_LSH);
    assign rsh_amt = RSH_W'(SH_W'(FRAC_TOP) - fields.shift);
    assign lsh_amt = LSH_W'(fields.shift - SH_W'(FRAC_TOP));

    assign rstage[0] = MAG_W'(fields.mant);
    assign lstage[0] = MAG_W'(fields.mant);

    for (genvar i = 0; i < RSH_W; i++) begin : g_rstage
        assign rstage[i+1] = rsh_amt[i] ? (rstage[i] >> (1 << i)) : rstage[i];
    end

    for (genvar j = 0; j < LSH_W; j++) begin : g_lstage
        assign lstage[j+1] = lsh_amt[j] ? (lstage[j] << (1 << j)) : lstage[j];
    end

    always_comb begin
        unique case (kind)
            KIND_RIGHT: mag = rstage[RSH_W];
            KIND_LEFT:  mag = lstage[LSH_W];
            default:    mag = '0;
        endcase
    end

    // R3
    right_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_RIGHT) |-> (mag <= MAG_W'(fields.mant) && mag != '0));

    // R5
    left_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_LEFT) |-> (mag > MAG_W'(fields.mant)));

endmodule

// File: rtl/flt2fix_sign.sv
module flt2fix_sign
    import flt2fix_pkg::*;
#(
    parameter int OUT_W = 11,
    parameter int MAG_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sign,
    input  shift_kind_e       kind,
    input  logic [MAG_W-1:0]  mag,
    output logic [OUT_W-1:0]  coef,
    output logic              ovf
);

    localparam logic [OUT_W-1:0] POS_LIMIT = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIMIT = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] mag_low;
    logic [OUT_W-1:0] neg_low;

    assign mag_low = mag[OUT_W-1:0];
    assign neg_low = (~mag_low) + OUT_W'(1);

    always_comb begin
        ovf  = (kind == KIND_SAT);
        if (ovf)
            coef = sign ? NEG_LIMIT : POS_LIMIT;
        else
            coef = sign ? neg_low : mag_low;
    end

    // R4
    zero_mag_zero_coef_chk: assert property (@(posedge clk) disable iff (rst)
        (kind != KIND_SAT && mag == '0) |-> (coef == '0));

endmodule

// File: rtl/flt2fix_coef.sv
module flt2fix_coef
    import flt2fix_pkg::*;
#(
    parameter int INT_W   = 2,
    parameter int FRAC_W  = 8,
    parameter int MAX_LSH = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [31:0]               in_word,
    output logic                      out_valid,
    output logic [INT_W+FRAC_W:0]     out_coef,
    output logic                      out_ovf
);

    localparam int OUT_W = INT_W + FRAC_W + 1;
    localparam int MAG_W = MANT_W + MAX_LSH;

    fields_t          fields;
    shift_kind_e      kind;
    logic [MAG_W-1:0] mag;
    logic [OUT_W-1:0] coef_nxt;
    logic             ovf_nxt;

    flt2fix_unpack #(.FRAC_W(FRAC_W)) unpack_i (
        .word   (in_word),
        .fields (fields)
    );

    flt2fix_shift #(.MAX_LSH(MAX_LSH), .MAG_W(MAG_W)) shift_i (
        .clk    (clk),
        .rst    (rst),
        .fields (fields),
        .kind   (kind),
        .mag    (mag)
    );

    flt2fix_sign #(.OUT_W(OUT_W), .MAG_W(MAG_W)) sign_i (
        .clk    (clk),
        .rst    (rst),
        .sign   (fields.sign),
        .kind   (kind),
        .mag    (mag),
        .coef   (coef_nxt),
        .ovf    (ovf_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_coef  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_coef <= coef_nxt;
                out_ovf  <= ovf_nxt;
            end
        end
    end

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_coef) && $stable(out_ovf)));

    // R7
    sat_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |-> (out_coef[OUT_W-1] == $past(in_word[31])));

    // R4
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && int'($past(in_word[30:23])) < EXP_BIAS - FRAC_W)
        |-> (out_coef == '0 && !out_ovf));

endmodule

// File: tb/flt2fix_coef_tb_top.sv
`timescale 1ns/1ps
module flt2fix_coef_tb_top;

    localparam int INT_W   = 2;
    localparam int FRAC_W  = 8;
    localparam int MAX_LSH = 7;
    localparam int OUT_W   = INT_W + FRAC_W + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [31:0]      in_word = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_coef;
    logic             out_ovf;

    int n_checks = 0;
    int n_fails  = 0;
    logic [OUT_W-1:0] held_coef = '0;
    logic             held_ovf  = 1'b0;

    always #4 clk = ~clk;

    flt2fix_coef #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MAX_LSH(MAX_LSH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_coef  (out_coef),
        .out_ovf   (out_ovf)
    );

    function automatic int eff_shift(input logic [31:0] w);
        return int'(w[30:23]) - 127 + FRAC_W;
    endfunction

    function automatic bit model_ovf(input logic [31:0] w);
        return eff_shift(w) > 23 + MAX_LSH;
    endfunction

    function automatic logic [OUT_W-1:0] model_coef(input logic [31:0] w);
        int     sh  = eff_shift(w);
        longint mag = longint'({1'b1, w[22:0]});
        if (sh > 23 + MAX_LSH)
            return w[31] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
        if (sh < 0)
            mag = 0;
        else if (sh > 23)
            mag = mag << (sh - 23);
        else
            mag = mag >> (23 - sh);
        if (w[31])
            mag = -mag;
        return mag[OUT_W-1:0];
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        int sh = eff_shift(w);
        if (sh < 0)                 return "R4";
        if (sh > 23 + MAX_LSH)      return "R7";
        if (w[31])                  return "R6";
        if (sh > 23)                return "R5";
        return "R3";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; drives one cycle and checks its result.
    task automatic step(input bit v, input logic [31:0] w);
        string t;
        in_valid = v;
        in_word  = w;
        @(negedge clk);
        check("R2", "out_valid", 32'(out_valid), 32'(v));
        if (v) begin
            held_coef = model_coef(w);
            held_ovf  = model_ovf(w);
            t = tag_of(w);
        end else begin
            t = "R8";
        end
        check(t, "out_coef", 32'(out_coef), 32'(held_coef));
        check(t, "out_ovf",  32'(out_ovf),  32'(held_ovf));
    endtask

    function automatic logic [31:0] rand_word();
        logic [7:0] e;
        if ($urandom_range(0, 3) == 0)
            e = 8'($urandom_range(1, 254));
        else
            e = 8'($urandom_range(110, 160));
        return {1'($urandom_range(0, 1)), e, 23'($urandom)};
    endfunction

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0EF));
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check("R1", "out_coef in reset",  32'(out_coef),  32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R1", "out_coef after reset",  32'(out_coef),  32'd0);
        check("R1", "out_ovf after reset",   32'(out_ovf),   32'd0);

        // directed corners
        step(1, 32'h3F800000);  // R3: 1.0 -> 0x100
        step(1, 32'h3FC00000);  // R3: 1.5 -> 0x180
        step(1, 32'h3FFFFFFF);  // R3: truncation -> 0x1FF
        step(1, 32'h3B800000);  // R3: 2^-8 -> 1
        step(0, 32'hFFFFFFFF);  // R8: idle word ignored
        step(1, 32'h3B000000);  // R4: 2^-9 -> 0
        step(1, 32'hBB000000);  // R4: -2^-9 -> 0
        step(1, 32'hBF800000);  // R6: -1.0 -> 0x700
        step(1, 32'hBB800000);  // R6: -2^-8 -> 0x7FF
        step(1, 32'h47800000);  // R5: shift 24, wraps
        step(1, 32'h4A800000);  // R5: left 7, no overflow
        step(1, 32'h4B000000);  // R7: left 8 -> 0x3FF
        step(0, 32'h12345678);  // R8: holds saturated value
        step(1, 32'hCB000000);  // R7: negative -> 0x400
        step(1, 32'h3F800000);  // R7 cleared by next result

        // random mix, back-to-back with gaps
        for (int k = 0; k < 600; k++) begin
            step($urandom_range(0, 4) != 0, rand_word());
        end
        step(0, '0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule